// File: doc/BRIEF.md
# Windowed Watchdog with Lock-After-First-Write Configuration

This block is a watchdog timer. Software must service it at regular intervals. If it does not, the block asks for a system reset. A small configuration register sets four things: the timeout length, which clock drives the counter, whether servicing is restricted to a window, and whether a stop request is allowed. After reset the register takes exactly one write. Every later write is dropped until the next reset, so a runaway program cannot turn the watchdog off or weaken it.

The counter has two possible sources. One is a slow low-power tick, nominally 1 kHz, sampled as a strobe on the system clock. The other is the system (bus) clock itself, advancing every cycle. Each source has its own set of three power-of-two timeouts, and a timeout select of zero switches the watchdog off. Windowed mode applies only with the bus source. In that mode a service counts only during the final quarter of the period, and a service that comes too early is treated as a fault. A stop request made while stop is not permitted also forces a reset, with its own cause code.

Top module: `winwdt_top`

## Requirements
- R1: After reset, `cfgRdData` reads 0x03 and `rstReq` and `rstCause` are 0. The register fields are: bits 1:0 timeout select (reset value 11), bit 2 clock source (0 = low-power tick, 1 = bus clock), bit 3 window enable, bit 4 stop permitted. Bits 7:5 always read 0.
- R2: The first `cfgWrEn` pulse after reset loads bits 4:0 of `cfgWrData`. Any further write leaves both the readback and the behaviour unchanged until reset.
- R3: With timeout select 00, no watchdog reset request is ever raised, and a service has no effect even when window enable is set.
- R4: With the low-power source, the counter advances only in cycles where `lpTick` is 1. Expiry comes on tick number 2^LP_EXP1, 2^LP_EXP2 or 2^LP_EXP3 after a clear, for selects 01, 10 and 11 (defaults 5, 8, 10).
- R5: With the bus source, expiry comes exactly 2^BUS_EXP1, 2^BUS_EXP2 or 2^BUS_EXP3 cycles after a clear, for selects 01, 10 and 11 (defaults 13, 16, 18).
- R6: On expiry, `rstReq` is 1 for one cycle with `rstCause` = 01, and counting restarts from zero.
- R7: A legal service clears the counter, so the next expiry is measured from the service cycle.
- R8: With window enable and the bus source, the window opens at count P - P/4 for period P. A service at a lower count raises `rstReq` with cause 01 in the next cycle. A service at or above that count is legal.
- R9: With the low-power source, window enable has no effect, and a service at any count is legal.
- R10: `stopReq` while stop is not permitted raises `rstReq` with `rstCause` = 10 in the next cycle. When stop is permitted, `stopReq` raises nothing.
- R11: When an illegal stop and a watchdog event happen in the same cycle, the cause is 01. A legal service in the cycle of the final tick prevents the expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (bus) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write value |
| cfgRdData | output | 8 | Current configuration readback |
| svcStrobe | input | 1 | Service (counter clear) request |
| lpTick | input | 1 | One-cycle strobe from the low-power timebase |
| stopReq | input | 1 | Request to enter stop mode |
| rstReq | output | 1 | Reset request, registered |
| rstCause | output | 2 | 00 none, 01 watchdog, 10 illegal stop |

## Verification
The hardest case to reach from the ports is the exact cycle where the window opens. A service is the only way to clear the counter, yet any service made too early trips a fault. The stimulus therefore lets a first expiry, or a deliberate early-service violation, clear the counter at a known edge. It then services at the last count before the window opens and at the first count inside it. The same known zero point is used to line up a stop request, and a service, with the final tick. A behavioural model is compared with the outputs in every cycle.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;
  localparam int CFG_W = 5;
  localparam logic [CFG_W-1:0] CFG_RST = 5'b00011;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_WDOG = 2'b01,
    CAUSE_STOP = 2'b10
  } cause_e;

  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic cfgLoad;
  } wdtStrobe_t;

  function automatic int maxOf(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction
endpackage

// File: rtl/winwdt_dpath.sv
module winwdt_dpath
  import winwdt_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdtStrobe_t       strb,
  input  logic [7:0]       cfgWrData,
  output logic [1:0]       cfgTmo,
  output logic             cfgClk,
  output logic             cfgWin,
  output logic             cfgStop,
  output logic             locked,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       cfgRdData
);
  logic [CFG_W-1:0] cfgQ;
  logic [CNT_W-1:0] cntQ;
  logic             lockQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgQ  <= CFG_RST;
      lockQ <= 1'b0;
    end else if (strb.cfgLoad) begin
      cfgQ  <= cfgWrData[CFG_W-1:0];
      lockQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cntQ <= '0;
    else if (strb.cntClr) cntQ <= '0;
    else if (strb.cntInc) cntQ <= cntQ + CNT_W'(1);
  end

  assign cfgTmo    = cfgQ[1:0];
  assign cfgClk    = cfgQ[2];
  assign cfgWin    = cfgQ[3];
  assign cfgStop   = cfgQ[4];
  assign locked    = lockQ;
  assign count     = cntQ;
  assign cfgRdData = {{(8-CFG_W){1'b0}}, cfgQ};

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    lockQ |=> $stable(cfgQ)); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cntClr |=> (cntQ == '0)); // R7
endmodule

// File: rtl/winwdt_ctrl.sv
module winwdt_ctrl
  import winwdt_pkg::*;
#(
  parameter int CNT_W    = 18,
  parameter int LP_EXP1  = 5,
  parameter int LP_EXP2  = 8,
  parameter int LP_EXP3  = 10,
  parameter int BUS_EXP1 = 13,
  parameter int BUS_EXP2 = 16,
  parameter int BUS_EXP3 = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrEn,
  input  logic             svcStrobe,
  input  logic             lpTick,
  input  logic             stopReq,
  input  logic             locked,
  input  logic [1:0]       cfgTmo,
  input  logic             cfgClk,
  input  logic             cfgWin,
  input  logic             cfgStop,
  input  logic [CNT_W-1:0] count,
  output wdtStrobe_t       strb,
  output logic             rstReq,
  output logic [1:0]       rstCause
);
  localparam int PW = CNT_W + 1;

  int          expV;
  logic [PW-1:0] periodV, lastIdx, openPt, cntExt;
  logic enabled, tick, winAct, early, legalSvc, expire, badStop;
  logic   reqQ;
  cause_e causeQ;

  always_comb begin
    case (cfgTmo)
      2'b01:   expV = cfgClk ? BUS_EXP1 : LP_EXP1;
      2'b10:   expV = cfgClk ? BUS_EXP2 : LP_EXP2;
      2'b11:   expV = cfgClk ? BUS_EXP3 : LP_EXP3;
      default: expV = 0;
    endcase
    periodV = PW'(1) << expV;
    lastIdx = periodV - PW'(1);
    openPt  = periodV - (periodV >> 2);
  end

  assign cntExt   = {1'b0, count};
  assign enabled  = (cfgTmo != 2'b00);
  assign tick     = enabled && (cfgClk || lpTick);
  assign winAct   = enabled && cfgWin && cfgClk;
  assign early    = svcStrobe && winAct && (cntExt < openPt);
  assign legalSvc = svcStrobe && enabled && !early;
  assign expire   = tick && (cntExt >= lastIdx) && !legalSvc;
  assign badStop  = stopReq && !cfgStop;

  always_comb begin
    strb.cfgLoad = cfgWrEn && !locked;
    strb.cntClr  = expire || early || legalSvc;
    strb.cntInc  = tick && !strb.cntClr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqQ   <= 1'b0;
      causeQ <= CAUSE_NONE;
    end else begin
      reqQ <= expire || early || badStop;
      if (expire || early) causeQ <= CAUSE_WDOG;
      else if (badStop)     causeQ <= CAUSE_STOP;
      else                  causeQ <= CAUSE_NONE;
    end
  end

  assign rstReq   = reqQ;
  assign rstCause = causeQ;

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgTmo == 2'b00) |=> (rstCause != CAUSE_WDOG)); // R3
  AST_LP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgClk && !lpTick && !svcStrobe) |=> $stable(count)); // R4
  AST_EARLY_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (svcStrobe && cfgWin && cfgClk && enabled && (cntExt < openPt))
      |=> (rstReq && rstCause == CAUSE_WDOG)); // R8
  AST_STOP_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (stopReq && !cfgStop) |=> rstReq); // R10
  AST_CAUSE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rstReq == (rstCause != CAUSE_NONE))); // R6
endmodule

// File: rtl/winwdt_top.sv
module winwdt_top
  import winwdt_pkg::*;
#(
  parameter int LP_EXP1  = 5,
  parameter int LP_EXP2  = 8,
  parameter int LP_EXP3  = 10,
  parameter int BUS_EXP1 = 13,
  parameter int BUS_EXP2 = 16,
  parameter int BUS_EXP3 = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  output logic [7:0] cfgRdData,
  input  logic       svcStrobe,
  input  logic       lpTick,
  input  logic       stopReq,
  output logic       rstReq,
  output logic [1:0] rstCause
);
  localparam int CNT_W = maxOf(maxOf(LP_EXP1, LP_EXP2, LP_EXP3),
                               maxOf(BUS_EXP1, BUS_EXP2, BUS_EXP3), 1);

  wdtStrobe_t       strb;
  logic [1:0]       cfgTmo;
  logic             cfgClk, cfgWin, cfgStop, locked;
  logic [CNT_W-1:0] count;

  winwdt_ctrl #(
    .CNT_W(CNT_W), .LP_EXP1(LP_EXP1), .LP_EXP2(LP_EXP2), .LP_EXP3(LP_EXP3),
    .BUS_EXP1(BUS_EXP1), .BUS_EXP2(BUS_EXP2), .BUS_EXP3(BUS_EXP3)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .svcStrobe(svcStrobe),
    .lpTick(lpTick), .stopReq(stopReq), .locked(locked), .cfgTmo(cfgTmo),
    .cfgClk(cfgClk), .cfgWin(cfgWin), .cfgStop(cfgStop), .count(count),
    .strb(strb), .rstReq(rstReq), .rstCause(rstCause)
  );

  winwdt_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cfgWrData(cfgWrData),
    .cfgTmo(cfgTmo), .cfgClk(cfgClk), .cfgWin(cfgWin), .cfgStop(cfgStop),
    .locked(locked), .count(count), .cfgRdData(cfgRdData)
  );
endmodule

// File: tb/tb_winwdt_top.sv
module tb_winwdt_top;
  localparam int CLK_PERIOD = 10;
  localparam int LPE[4]  = '{0, 2, 3, 4};
  localparam int BUSE[4] = '{0, 5, 7, 9};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic       svcStrobe = 1'b0;
  logic       lpTick = 1'b0;
  logic       stopReq = 1'b0;
  logic [7:0] cfgRdData;
  logic       rstReq;
  logic [1:0] rstCause;

  int total = 0;
  int bad = 0;

  winwdt_top #(
    .LP_EXP1(LPE[1]), .LP_EXP2(LPE[2]), .LP_EXP3(LPE[3]),
    .BUS_EXP1(BUSE[1]), .BUS_EXP2(BUSE[2]), .BUS_EXP3(BUSE[3])
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .svcStrobe(svcStrobe), .lpTick(lpTick),
    .stopReq(stopReq), .rstReq(rstReq), .rstCause(rstCause)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int mTmo, mClk, mWin, mStop, mLock, mCnt, mCause;
  bit mReq;
  always @(posedge clk) begin
    if (!rst_n) begin
      mTmo = 3; mClk = 0; mWin = 0; mStop = 0; mLock = 0; mCnt = 0;
      mReq = 0; mCause = 0;
    end else begin
      int per, openAt;
      bit en, tk, early, legal, tout, sBad;
      per    = 1 << (mClk != 0 ? BUSE[mTmo] : LPE[mTmo]);
      openAt = per - per / 4;
      en     = (mTmo != 0);
      tk     = en && (mClk != 0 || lpTick);
      early  = svcStrobe && en && mWin != 0 && mClk != 0 && mCnt < openAt;
      legal  = svcStrobe && en && !early;
      tout   = tk && mCnt >= per - 1 && !legal;
      sBad   = stopReq && mStop == 0;
      mReq   = tout || early || sBad;
      mCause = (tout || early) ? 1 : (sBad ? 2 : 0);
      if (tout || early || legal) mCnt = 0;
      else if (tk) mCnt = mCnt + 1;
      if (cfgWrEn && mLock == 0) begin
        mTmo = cfgWrData[1:0]; mClk = cfgWrData[2]; mWin = cfgWrData[3];
        mStop = cfgWrData[4]; mLock = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 model cfgRdData", cfgRdData,
          {3'b000, mStop[0], mWin[0], mClk[0], mTmo[1:0]});
      chk("R6 model rstReq", rstReq, mReq);
      chk("R10 model rstCause", rstCause, mCause);
    end
  end

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask
  task automatic wr(input logic [7:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask
  task automatic svc();
    svcStrobe = 1'b1; @(negedge clk); svcStrobe = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic runToReq(input bit useLp, input int limit,
                          output int cyc, output int ticks);
    cyc = 0; ticks = 0;
    while (!rstReq && cyc < limit) begin
      lpTick = useLp && (cyc % 3 == 0);
      if (lpTick) ticks++;
      cyc++;
      @(negedge clk);
    end
    lpTick = 1'b0;
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, t, p;
    doReset();
    // R1 reset state
    chk("R1 cfg reset", cfgRdData, 8'h03);
    chk("R1 rstReq reset", rstReq, 0);
    chk("R1 cause reset", rstCause, 0);

    // R2 write once, upper bits dropped; R5/R6 bus timeouts
    for (int s = 1; s <= 3; s++) begin
      doReset();
      wr(8'hE0 | 8'h04 | s[7:0]);
      chk("R2 first write", cfgRdData, 8'h04 | s);
      wr(8'h10);
      chk("R2 second write ignored", cfgRdData, 8'h04 | s);
      p = 1 << BUSE[s];
      svc();
      runToReq(0, 4 * p, c, t);
      chk("R5 bus expiry cycles", c, p);
      chk("R6 cause watchdog", rstCause, 1);
      @(negedge clk);
      chk("R6 single-cycle pulse", rstReq, 0);
      runToReq(0, 4 * p, c, t);
      chk("R6 restart from zero", c, p - 1);
    end

    // R4 low-power timeouts
    for (int s = 1; s <= 3; s++) begin
      doReset();
      wr(s[7:0]);
      svc();
      runToReq(1, 1000, c, t);
      chk("R4 lp tick count", t, 1 << LPE[s]);
      chk("R4 only ticks advance", c, 3 * ((1 << LPE[s]) - 1) + 1);
    end

    // R8 window boundary (bus, select 01)
    doReset();
    wr(8'h0D);
    p = 1 << BUSE[1];
    runToReq(0, 4 * p, c, t);           // counter now known zero
    chk("R6 first expiry", rstReq, 1);
    idle(p - p / 4 - 1);
    svc();
    chk("R8 service before window", rstReq, 1);
    chk("R8 violation cause", rstCause, 1);
    idle(p - p / 4);
    svc();
    chk("R8 service at window open", rstReq, 0);
    runToReq(0, 4 * p, c, t);
    chk("R7 expiry from service", c, p);

    // R9 window ignored on low-power source
    doReset();
    wr(8'h09);
    svc();
    chk("R9 early service legal", rstReq, 0);
    runToReq(1, 1000, c, t);
    chk("R9 lp expiry", t, 1 << LPE[1]);

    // R3 disabled
    doReset();
    wr(8'h0C);
    svc();
    chk("R3 service ignored", rstReq, 0);
    runToReq(0, 2000, c, t);
    chk("R3 never expires", c, 2000);

    // R10 stop handling
    doReset();
    stopReq = 1'b1; @(negedge clk); stopReq = 1'b0;
    chk("R10 illegal stop req", rstReq, 1);
    chk("R10 illegal stop cause", rstCause, 2);
    doReset();
    wr(8'h10);
    stopReq = 1'b1; @(negedge clk); stopReq = 1'b0;
    chk("R10 permitted stop", rstReq, 0);

    // R11 coincident events
    doReset();
    wr(8'h05);
    p = 1 << BUSE[1];
    svc();
    idle(p - 1);
    stopReq = 1'b1; @(negedge clk); stopReq = 1'b0;
    chk("R11 coincident req", rstReq, 1);
    chk("R11 watchdog cause wins", rstCause, 1);
    idle(p - 1);
    svc();
    chk("R11 service on final tick", rstReq, 0);
    runToReq(0, 4 * p, c, t);
    chk("R7 expiry after final-tick service", c, p);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule